// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write cycles of an asynchronous flash-style bus (active-low chip, output and write enables, 17-bit address, 16-bit data) from a synchronous clock domain. It recognises keyed command sequences and turns them into one-cycle strobes. Each sequence opens with a two-write unlock handshake. The third write then picks a branch: word program, the six-write erase family, or identification mode. The block also holds the address and data that the command needs. The operation engine that acts on the strobes lives outside.

The control pins pass through a synchronizer. A write is taken only after a write-enable low pulse of at least `GLITCH_CYC` clock cycles. The write's address is captured at the falling edge of the pulse and its data at the rising edge. A read in the middle of a sequence sends the state machine back to `ST_IDLE`. So do a mismatched write and a bus reset held long enough. While the operation engine is busy, writes are dropped.

States: `ST_IDLE` moves to `ST_KEY1` on the first key. `ST_KEY1` moves to `ST_KEY2` on the second key. From `ST_KEY2`, the program code leads to `ST_PROG_ARM`, the erase-family code leads to `ST_ERS_KEY0`, and the ID-entry or ID-exit codes fire their strobe and return to `ST_IDLE`. `ST_PROG_ARM` returns to `ST_IDLE` with a program strobe on the next write. `ST_ERS_KEY0` moves to `ST_ERS_KEY1`, then to `ST_ERS_KEY2`. `ST_ERS_KEY2` returns to `ST_IDLE` with a chip, lockout or sector strobe. Any mismatch returns to `ST_IDLE`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After the clock-domain reset, all six strobes are 0, `id_mode` is 0 and `cmd_addr`/`cmd_data` are 0.
- R2: The writes AA@5555, 55@2AAA, A0@5555 followed by a fourth write to any address give one `prog_stb` pulse. `cmd_addr`/`cmd_data` then hold that fourth write's address and full data. Key compares use address bits 14..0 and data bits 7..0 only, so address bit 16 and data bits 15..8 do not matter.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA followed by 10@5555 give one `chip_erase_stb` pulse. The same five followed by 40@5555 give one `lock_set_stb` pulse.
- R4: The same five-write prefix followed by data 30 at any address gives one `sector_erase_stb` pulse. `cmd_addr` holds the address present when write enable fell, not the address present when it rose.
- R5: AA@5555, 55@2AAA, 90@5555 gives `id_enter_stb` and sets `id_mode`. Either AA@5555, 55@2AAA, F0@5555, or a single F0 write at any address from `ST_IDLE`, gives `id_exit_stb` and clears `id_mode`.
- R6: A write that does not match the expected key at its step returns the sequence to `ST_IDLE` with no strobe. This applies at the second step and at the sixth step.
- R7: A read cycle (chip and output enable both low) during a sequence aborts it. A read does not change `id_mode`.
- R8: A write-enable pulse with chip enable high, or with output enable low, is not a write.
- R9: A write-enable low pulse shorter than `GLITCH_CYC` cycles is ignored, and the sequence keeps its state.
- R10: `bus_rst_n` low for at least `RST_MIN_CYC` cycles returns the sequence to `ST_IDLE` and clears `id_mode`. A shorter low pulse has no effect.
- R11: Writes that complete while `eng_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Clock-domain reset, active low |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_rst_n | input | 1 | Bus-side reset, active low, filtered by duration |
| bus_addr | input | 17 | Bus address |
| bus_data | input | 16 | Bus write data |
| eng_busy | input | 1 | Operation engine busy, writes ignored |
| prog_stb | output | 1 | Word program strobe |
| chip_erase_stb | output | 1 | Chip erase strobe |
| sector_erase_stb | output | 1 | Sector erase strobe |
| lock_set_stb | output | 1 | Lockout set strobe |
| id_enter_stb | output | 1 | Identification entry strobe |
| id_exit_stb | output | 1 | Identification exit strobe |
| id_mode | output | 1 | Identification mode active |
| cmd_addr | output | 17 | Target address of the last command |
| cmd_data | output | 16 | Data of the last command |

## Verification
Every branch is driven with a full valid sequence. Key writes carry a set address bit 16 and non-zero upper data bytes, which separates correct narrow compares from full-width ones. Invalid patterns are run against otherwise good sequences: a wrong second key, a wrong sixth code, a read between keys, chip-enable-high and output-enable-low pulses, and a glitch-width pulse. A following good write then shows whether the bad cycle reset the sequence or left it intact. For sector erase the address changes while write enable is low, which separates a capture at the falling edge from one at the rising edge. Bus reset pulses of two lengths check the duration filter.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    localparam int KEY_AW = 15;
    localparam logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0] KEY_D1    = 8'hAA;
    localparam logic [7:0] KEY_D2    = 8'h55;
    localparam logic [7:0] OP_PROG   = 8'hA0;
    localparam logic [7:0] OP_ERSFAM = 8'h80;
    localparam logic [7:0] OP_ID_IN  = 8'h90;
    localparam logic [7:0] OP_ID_OUT = 8'hF0;
    localparam logic [7:0] OP_CHIP   = 8'h10;
    localparam logic [7:0] OP_LOCK   = 8'h40;
    localparam logic [7:0] OP_SECT   = 8'h30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG_ARM,
        ST_ERS_KEY0,
        ST_ERS_KEY1,
        ST_ERS_KEY2
    } seq_state_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_PROG,
        EV_CHIP,
        EV_SECT,
        EV_LOCK,
        EV_ID_IN,
        EV_ID_OUT
    } seq_evt_t;
endpackage

// File: rtl/fcd_sync.sv
module fcd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '1;
                    else        chain[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '1;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/fcd_bus_watch.sv
module fcd_bus_watch #(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 16,
    parameter int GLITCH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              oe_s,
    input  logic              we_s,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_stb
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(GLITCH_CYC);

    logic              wr_lvl, wr_lvl_q;
    logic              rd_lvl, rd_lvl_q;
    logic              wr_end_ok;
    logic [CW-1:0]     width_cnt;
    logic [ADDR_W-1:0] addr_lat;

    assign wr_lvl    = !ce_s && oe_s && !we_s;
    assign rd_lvl    = !ce_s && !oe_s;
    assign wr_end_ok = wr_lvl_q && !wr_lvl && !ce_s && oe_s && we_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_lvl_q  <= 1'b0;
            rd_lvl_q  <= 1'b0;
            width_cnt <= '0;
            addr_lat  <= '0;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            rd_stb    <= 1'b0;
        end else begin
            wr_lvl_q <= wr_lvl;
            rd_lvl_q <= rd_lvl;
            rd_stb   <= rd_lvl && !rd_lvl_q;
            wr_stb   <= 1'b0;
            if (wr_lvl && !wr_lvl_q) begin
                addr_lat  <= bus_addr;
                width_cnt <= CW'(1);
            end else if (wr_lvl && width_cnt < CNT_MAX) begin
                width_cnt <= width_cnt + CW'(1);
            end
            if (wr_end_ok && width_cnt >= CNT_MAX) begin
                wr_stb  <= 1'b1;
                wr_addr <= addr_lat;
                wr_data <= bus_data;
            end
        end
    end
endmodule

// File: rtl/fcd_rst_filter.sv
module fcd_rst_filter #(
    parameter int RST_MIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst_s,
    output logic clr
);
    localparam int RW = $clog2(RST_MIN_CYC + 1);
    localparam logic [RW-1:0] HOLD_MAX = RW'(RST_MIN_CYC);

    logic [RW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_cnt <= '0;
        else if (bus_rst_s)      low_cnt <= '0;
        else if (low_cnt != HOLD_MAX) low_cnt <= low_cnt + RW'(1);
    end

    assign clr = (low_cnt == HOLD_MAX);
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              clr,
    input  logic              busy,
    output seq_state_t        state,
    output logic              prog_stb,
    output logic              chip_erase_stb,
    output logic              sector_erase_stb,
    output logic              lock_set_stb,
    output logic              id_enter_stb,
    output logic              id_exit_stb,
    output logic              id_mode,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    seq_state_t nxt;
    seq_evt_t   evt;
    logic       step, at_a, at_b;
    logic [7:0] dlo;

    assign step = wr_stb && !busy;
    assign at_a = (wr_addr[KEY_AW-1:0] == KEY_ADDR_A);
    assign at_b = (wr_addr[KEY_AW-1:0] == KEY_ADDR_B);
    assign dlo  = wr_data[7:0];

    always_comb begin
        nxt = state;
        evt = EV_NONE;
        if (clr || rd_stb) begin
            nxt = ST_IDLE;
        end else if (step) begin
            unique case (state)
                ST_IDLE: begin
                    if (at_a && dlo == KEY_D1) nxt = ST_KEY1;
                    else if (dlo == OP_ID_OUT) evt = EV_ID_OUT;
                end
                ST_KEY1: nxt = (at_b && dlo == KEY_D2) ? ST_KEY2 : ST_IDLE;
                ST_KEY2: begin
                    nxt = ST_IDLE;
                    if (at_a) begin
                        if (dlo == OP_PROG)        nxt = ST_PROG_ARM;
                        else if (dlo == OP_ERSFAM) nxt = ST_ERS_KEY0;
                        else if (dlo == OP_ID_IN)  evt = EV_ID_IN;
                        else if (dlo == OP_ID_OUT) evt = EV_ID_OUT;
                    end
                end
                ST_PROG_ARM: begin
                    nxt = ST_IDLE;
                    evt = EV_PROG;
                end
                ST_ERS_KEY0: nxt = (at_a && dlo == KEY_D1) ? ST_ERS_KEY1 : ST_IDLE;
                ST_ERS_KEY1: nxt = (at_b && dlo == KEY_D2) ? ST_ERS_KEY2 : ST_IDLE;
                ST_ERS_KEY2: begin
                    nxt = ST_IDLE;
                    if (dlo == OP_SECT)             evt = EV_SECT;
                    else if (at_a && dlo == OP_CHIP) evt = EV_CHIP;
                    else if (at_a && dlo == OP_LOCK) evt = EV_LOCK;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_stb         <= 1'b0;
            chip_erase_stb   <= 1'b0;
            sector_erase_stb <= 1'b0;
            lock_set_stb     <= 1'b0;
            id_enter_stb     <= 1'b0;
            id_exit_stb      <= 1'b0;
            id_mode          <= 1'b0;
            cmd_addr         <= '0;
            cmd_data         <= '0;
        end else begin
            prog_stb         <= (evt == EV_PROG);
            chip_erase_stb   <= (evt == EV_CHIP);
            sector_erase_stb <= (evt == EV_SECT);
            lock_set_stb     <= (evt == EV_LOCK);
            id_enter_stb     <= (evt == EV_ID_IN);
            id_exit_stb      <= (evt == EV_ID_OUT);
            if (clr || evt == EV_ID_OUT) id_mode <= 1'b0;
            else if (evt == EV_ID_IN)    id_mode <= 1'b1;
            if (evt == EV_PROG || evt == EV_CHIP || evt == EV_SECT || evt == EV_LOCK) begin
                cmd_addr <= wr_addr;
                cmd_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_CYC  = 3,
    parameter int RST_MIN_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic              bus_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              eng_busy,
    output logic              prog_stb,
    output logic              chip_erase_stb,
    output logic              sector_erase_stb,
    output logic              lock_set_stb,
    output logic              id_enter_stb,
    output logic              id_exit_stb,
    output logic              id_mode,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    localparam int CTRL_W = 4;

    logic [CTRL_W-1:0] ctrl_s;
    logic              wr_stb, rd_stb, bus_clr;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    seq_state_t        seq_state;

    fcd_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({bus_rst_n, bus_we_n, bus_oe_n, bus_ce_n}),
        .d_sync  (ctrl_s)
    );

    fcd_bus_watch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_s     (ctrl_s[0]),
        .oe_s     (ctrl_s[1]),
        .we_s     (ctrl_s[2]),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb)
    );

    fcd_rst_filter #(.RST_MIN_CYC(RST_MIN_CYC)) u_rstf (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst_s (ctrl_s[3]),
        .clr       (bus_clr)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_stb           (wr_stb),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .rd_stb           (rd_stb),
        .clr              (bus_clr),
        .busy             (eng_busy),
        .state            (seq_state),
        .prog_stb         (prog_stb),
        .chip_erase_stb   (chip_erase_stb),
        .sector_erase_stb (sector_erase_stb),
        .lock_set_stb     (lock_set_stb),
        .id_enter_stb     (id_enter_stb),
        .id_exit_stb      (id_exit_stb),
        .id_mode          (id_mode),
        .cmd_addr         (cmd_addr),
        .cmd_data         (cmd_data)
    );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       eng_busy,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic       bus_clr,
    input seq_state_t seq_state,
    input logic       prog_stb,
    input logic       chip_erase_stb,
    input logic       sector_erase_stb,
    input logic       lock_set_stb,
    input logic       id_enter_stb,
    input logic       id_exit_stb,
    input logic       id_mode
);
    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, chip_erase_stb, sector_erase_stb, lock_set_stb, id_enter_stb, id_exit_stb}));

    // R2
    prog_from_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |-> $past(seq_state) == ST_PROG_ARM);

    // R3
    erase_from_key2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_erase_stb || lock_set_stb || sector_erase_stb) |-> $past(seq_state) == ST_ERS_KEY2);

    // R5
    id_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_enter_stb |-> (id_mode && $past(seq_state) == ST_KEY2));

    // R7
    read_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> seq_state == ST_IDLE);

    // R10
    bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clr |=> (seq_state == ST_IDLE && !id_mode));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && eng_busy && !bus_clr) |=> $stable(seq_state));
endmodule

bind flash_cmd_decoder fcd_checker i_fcd_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .eng_busy         (eng_busy),
    .wr_stb           (wr_stb),
    .rd_stb           (rd_stb),
    .bus_clr          (bus_clr),
    .seq_state        (seq_state),
    .prog_stb         (prog_stb),
    .chip_erase_stb   (chip_erase_stb),
    .sector_erase_stb (sector_erase_stb),
    .lock_set_stb     (lock_set_stb),
    .id_enter_stb     (id_enter_stb),
    .id_exit_stb      (id_exit_stb),
    .id_mode          (id_mode)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1, bus_rst_n = 1'b1;
    logic [16:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        eng_busy = 1'b0;
    logic        prog_stb, chip_erase_stb, sector_erase_stb, lock_set_stb;
    logic        id_enter_stb, id_exit_stb, id_mode;
    logic [16:0] cmd_addr;
    logic [15:0] cmd_data;

    int total = 0;
    int bad   = 0;
    int n_prog = 0, n_chip = 0, n_sect = 0, n_lock = 0, n_in = 0, n_out = 0;
    int s_prog, s_chip, s_sect, s_lock, s_in, s_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_rst_n(bus_rst_n), .bus_addr(bus_addr),
        .bus_data(bus_data), .eng_busy(eng_busy), .prog_stb(prog_stb),
        .chip_erase_stb(chip_erase_stb), .sector_erase_stb(sector_erase_stb),
        .lock_set_stb(lock_set_stb), .id_enter_stb(id_enter_stb),
        .id_exit_stb(id_exit_stb), .id_mode(id_mode), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data)
    );

    always @(negedge clk) begin
        if (prog_stb)         n_prog++;
        if (chip_erase_stb)   n_chip++;
        if (sector_erase_stb) n_sect++;
        if (lock_set_stb)     n_lock++;
        if (id_enter_stb)     n_in++;
        if (id_exit_stb)      n_out++;
    end

    task automatic chk(input string req, input logic ok, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mark();
        s_prog = n_prog; s_chip = n_chip; s_sect = n_sect;
        s_lock = n_lock; s_in = n_in; s_out = n_out;
    endtask

    // expected strobe counts since mark, packed p,c,s,l,i,o as hex nibbles
    task automatic expect_counts(input string req, input int p, input int c, input int s,
                                 input int l, input int i, input int o);
        int act, exp;
        act = ((n_prog-s_prog) << 20) | ((n_chip-s_chip) << 16) | ((n_sect-s_sect) << 12) |
              ((n_lock-s_lock) << 8) | ((n_in-s_in) << 4) | (n_out-s_out);
        exp = (p << 20) | (c << 16) | (s << 12) | (l << 8) | (i << 4) | o;
        chk(req, act == exp, act, exp);
    endtask

    task automatic bus_write(input logic [16:0] a, input logic [15:0] d,
                             input int width = 5, input logic ce_val = 1'b0,
                             input logic oe_val = 1'b1);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_ce_n = ce_val; bus_oe_n = oe_val;
        repeat (2) @(negedge clk);
        bus_we_n = 1'b0;
        repeat (width) @(negedge clk);
        bus_we_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_ce_n = 1'b1; bus_oe_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_read();
        @(negedge clk);
        bus_ce_n = 1'b0; bus_oe_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_ce_n = 1'b1; bus_oe_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic unlock();
        bus_write(17'h15555, 16'h37AA);
        bus_write(17'h12AAA, 16'hC855);
    endtask

    task automatic erase_prefix();
        unlock();
        bus_write(17'h05555, 16'h0080);
        bus_write(17'h05555, 16'h00AA);
        bus_write(17'h02AAA, 16'h0055);
    endtask

    task automatic t_reset();
        chk("R1 strobes", {prog_stb, chip_erase_stb, sector_erase_stb, lock_set_stb,
            id_enter_stb, id_exit_stb} == 6'b0, {prog_stb, chip_erase_stb}, 0);
        chk("R1 id_mode", id_mode == 1'b0, id_mode, 0);
        chk("R1 cmd_addr", cmd_addr == 17'h0, cmd_addr, 0);
        chk("R1 cmd_data", cmd_data == 16'h0, cmd_data, 0);
    endtask

    task automatic t_program();
        mark();
        unlock();
        bus_write(17'h05555, 16'hFFA0);
        bus_write(17'h0ABCD, 16'h1234);
        expect_counts("R2 program strobe", 1, 0, 0, 0, 0, 0);
        chk("R2 cmd_addr", cmd_addr == 17'h0ABCD, cmd_addr, 17'h0ABCD);
        chk("R2 cmd_data", cmd_data == 16'h1234, cmd_data, 16'h1234);
    endtask

    task automatic t_chip_lock();
        mark();
        erase_prefix();
        bus_write(17'h05555, 16'h0010);
        expect_counts("R3 chip erase", 0, 1, 0, 0, 0, 0);
        mark();
        erase_prefix();
        bus_write(17'h05555, 16'h5540);
        expect_counts("R3 lockout set", 0, 0, 0, 1, 0, 0);
    endtask

    task automatic t_sector();
        mark();
        erase_prefix();
        @(negedge clk);
        bus_addr = 17'h05123; bus_data = 16'h0030; bus_ce_n = 1'b0; bus_oe_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_we_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_addr = 17'h1FFFF;
        repeat (2) @(negedge clk);
        bus_we_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_ce_n = 1'b1;
        repeat (5) @(negedge clk);
        expect_counts("R4 sector erase", 0, 0, 1, 0, 0, 0);
        chk("R4 sector address at fall", cmd_addr == 17'h05123, cmd_addr, 17'h05123);
    endtask

    task automatic t_ident();
        mark();
        unlock();
        bus_write(17'h05555, 16'h0090);
        expect_counts("R5 id entry", 0, 0, 0, 0, 1, 0);
        chk("R5 id_mode set", id_mode == 1'b1, id_mode, 1);
        unlock();
        bus_write(17'h05555, 16'h00F0);
        chk("R5 id_mode cleared by 3-write exit", id_mode == 1'b0, id_mode, 0);
        unlock();
        bus_write(17'h05555, 16'h0090);
        mark();
        bus_write(17'h01234, 16'h00F0);
        expect_counts("R5 single-write exit", 0, 0, 0, 0, 0, 1);
        chk("R5 id_mode cleared by single exit", id_mode == 1'b0, id_mode, 0);
    endtask

    task automatic t_mismatch();
        mark();
        bus_write(17'h05555, 16'h00AA);
        bus_write(17'h02AAA, 16'h0054);
        bus_write(17'h05555, 16'h00A0);
        bus_write(17'h00100, 16'h0000);
        expect_counts("R6 wrong second key", 0, 0, 0, 0, 0, 0);
        mark();
        erase_prefix();
        bus_write(17'h05555, 16'h0020);
        bus_write(17'h05555, 16'h0010);
        expect_counts("R6 wrong sixth code", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_read_abort();
        mark();
        unlock();
        bus_read();
        bus_write(17'h05555, 16'h00A0);
        bus_write(17'h00200, 16'h0BAD);
        expect_counts("R7 read aborts", 0, 0, 0, 0, 0, 0);
        unlock();
        bus_write(17'h05555, 16'h0090);
        bus_read();
        chk("R7 read keeps id_mode", id_mode == 1'b1, id_mode, 1);
        bus_write(17'h00000, 16'h00F0);
    endtask

    task automatic t_qualify();
        mark();
        unlock();
        bus_write(17'h05555, 16'h00A0);
        bus_write(17'h00300, 16'hDEAD, 5, 1'b1, 1'b1);
        expect_counts("R8 ce high is no write", 0, 0, 0, 0, 0, 0);
        bus_write(17'h00301, 16'hBEEF);
        expect_counts("R8 sequence kept", 1, 0, 0, 0, 0, 0);
        chk("R8 cmd_addr", cmd_addr == 17'h00301, cmd_addr, 17'h00301);
        unlock();
        bus_write(17'h05555, 16'h0090);
        mark();
        bus_write(17'h00000, 16'h00F0, 5, 1'b0, 1'b0);
        expect_counts("R8 oe low is no write", 0, 0, 0, 0, 0, 0);
        chk("R8 id_mode kept", id_mode == 1'b1, id_mode, 1);
        bus_write(17'h00000, 16'h00F0);
    endtask

    task automatic t_glitch();
        mark();
        unlock();
        bus_write(17'h05555, 16'h00A0);
        bus_write(17'h00400, 16'h1111, 1);
        expect_counts("R9 glitch ignored", 0, 0, 0, 0, 0, 0);
        bus_write(17'h00401, 16'h2222);
        expect_counts("R9 sequence kept", 1, 0, 0, 0, 0, 0);
        chk("R9 cmd_data", cmd_data == 16'h2222, cmd_data, 16'h2222);
    endtask

    task automatic t_bus_reset();
        unlock();
        bus_write(17'h05555, 16'h0090);
        mark();
        unlock();
        bus_write(17'h05555, 16'h00A0);
        @(negedge clk); bus_rst_n = 1'b0;
        repeat (3) @(negedge clk); bus_rst_n = 1'b1;
        repeat (5) @(negedge clk);
        bus_write(17'h00500, 16'h3333);
        expect_counts("R10 short reset ignored", 1, 0, 0, 0, 0, 0);
        chk("R10 id_mode kept", id_mode == 1'b1, id_mode, 1);
        mark();
        unlock();
        bus_write(17'h05555, 16'h00A0);
        @(negedge clk); bus_rst_n = 1'b0;
        repeat (14) @(negedge clk); bus_rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 id_mode cleared", id_mode == 1'b0, id_mode, 0);
        bus_write(17'h00501, 16'h4444);
        expect_counts("R10 sequence cleared", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_busy();
        mark();
        eng_busy = 1'b1;
        unlock();
        bus_write(17'h05555, 16'h00A0);
        bus_write(17'h00600, 16'h5555);
        eng_busy = 1'b0;
        bus_write(17'h00601, 16'h6666);
        expect_counts("R11 busy ignores writes", 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_program();
        t_chip_lock();
        t_sector();
        t_ident();
        t_mismatch();
        t_read_abort();
        t_qualify();
        t_glitch();
        t_bus_reset();
        t_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule